// File: doc/BRIEF.md
# External Memory Access Controller

A processor-side peripheral that converts simple register accesses into word transfers on a narrow external memory bus. One configuration bit chooses the target. A DRAM target uses a 4-bit data path, row and column addresses sent on shared pins, and periodic refresh. An SRAM target uses an 8-bit data path, a flat address and one of four wait settings. A 16- or 24-bit processor word is built from several external beats, least significant piece first.

Software sets a base address and two offset registers, then starts transfers. Writing the write-data register starts a write. A read starts in one of two ways, chosen by a mode bit: writing an offset register, or reading the read-data register. The register port has no back-pressure. Every access completes in the cycle it is presented, and the busy flag is the only flow control. While busy is set, further accesses are refused and flagged. Completion sets a done flag, and it can raise an interrupt.

Register map (reg_addr): 0 = config/status, 1 = write data, 2 = read data, 3 = base, 4 = offset A, 5 = offset B. Config bits: [0] target (0 DRAM, 1 SRAM), [2:1] word size code, [4:3] SRAM wait code, [7:5] refresh divider, [8] read trigger mode, [9] offset select, [10] interrupt enable. Status bits on read of address 0: [16] busy, [17] done, [18] error.

Top module: `xmem_ctrl`

## Requirements
- R1: After reset, the status register reads 0, irq is 0, and mem_ras, mem_cas, mem_cs, mem_we and mem_refresh are all 0.
- R2: A DRAM word is moved in 4 nibble beats (size code 0 or 1, 16 bits) or 6 nibble beats (size code 2 or 3, 24 bits) on mem_dout[3:0] / mem_din[3:0]. Each beat is one mem_cas cycle, beat k carries word bits [4k+3:4k], and mem_beat holds k.
- R3: An SRAM word is moved in 1, 2 or 3 byte beats (size code 0, 1, 2 or 3 giving 8, 16, 24, 24 bits). Beat k carries word bits [8k+7:8k]. A read returns the word zero-extended to 24 bits.
- R4: A DRAM access opens with one mem_ras cycle that drives the effective address bits [25:13] on mem_addr[12:0]. Every beat that follows drives bits [12:0] of the effective address.
- R5: An SRAM beat keeps mem_cs high for (wait code + 1) cycles and drives the effective address modulo 2^22 on mem_addr.
- R6: The effective address is (base + selected offset) modulo 2^26. A write to address 1 starts a write of reg_wdata[23:0] using the offset picked by config bit 9 (0 = A, 1 = B).
- R7: With config bit 8 = 0, a write to address 4 or 5 stores the offset and starts a read at base plus that new offset.
- R8: With config bit 8 = 1, offset writes start nothing. A read of address 2 returns the last completed read word and starts a read at base plus the selected offset.
- R9: A refresh request is raised every REF_BASE << divider cycles. It is served only between word transfers, as a mem_refresh pulse of REF_CYC cycles. An access requested during a refresh waits for it to end.
- R10: Busy is set from the cycle after a start until the last beat completes. The done flag is set at completion and cleared by the next start. irq equals done AND config bit 10.
- R11: While busy is set, a register write or a triggering read of address 2 is ignored and sets the error bit. A config write with reg_wdata[31] = 1, made while idle, clears the error bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects only for the read-data register) |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| irq | output | 1 | Completion interrupt |
| mem_ras | output | 1 | DRAM row address strobe |
| mem_cas | output | 1 | DRAM column strobe, one per nibble beat |
| mem_cs | output | 1 | SRAM select, held for each byte beat |
| mem_we | output | 1 | Write enable during access cycles |
| mem_refresh | output | 1 | DRAM refresh strobe |
| mem_addr | output | SA_W | Row, column or SRAM address |
| mem_beat | output | 3 | Beat index within the word |
| mem_dout | output | 8 | Write data (nibble in [3:0] for DRAM) |
| mem_din | input | 8 | Read data (nibble in [3:0] for DRAM) |

## Verification
The bench builds the block with the default geometry (ROW_W = 13, SA_W = 22) and with REF_BASE = 16, REF_CYC = 2. The default geometry lets an offset wrap the 26-bit address space and lets an SRAM address lose its upper bits. The small refresh base gives refresh intervals of 16 and 64 cycles that can be measured in a short run. At divider 0, refresh requests also keep landing inside long SRAM words with four wait cycles per beat, which tests that a word is never split and that a waiting access is held.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
  localparam int WORD_W = 24;
  localparam int REG_W  = 32;

  localparam logic [2:0] RA_CFG  = 3'd0;
  localparam logic [2:0] RA_WDAT = 3'd1;
  localparam logic [2:0] RA_RDAT = 3'd2;
  localparam logic [2:0] RA_BASE = 3'd3;
  localparam logic [2:0] RA_OFSA = 3'd4;
  localparam logic [2:0] RA_OFSB = 3'd5;

  localparam int CFG_W    = 11;
  localparam int CB_SRAM  = 0;
  localparam int CB_RDM   = 8;
  localparam int CB_OSEL  = 9;
  localparam int CB_IRQ   = 10;
  localparam int SB_BUSY  = 16;
  localparam int SB_DONE  = 17;
  localparam int SB_ERR   = 18;
  localparam int WB_ECLR  = 31;

  typedef enum logic [1:0] {SQ_IDLE, SQ_REF, SQ_ROW, SQ_BEAT} sq_state_e;

  function automatic logic [2:0] beats_of(input logic sram, input logic [1:0] size);
    if (sram) return (size == 2'd0) ? 3'd1 : (size == 2'd1) ? 3'd2 : 3'd3;
    return size[1] ? 3'd6 : 3'd4;
  endfunction
endpackage

// File: rtl/xmem_refresh.sv
module xmem_refresh #(
  parameter int REF_BASE = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] div,
  input  logic       ack,
  output logic       req
);
  localparam int CW = $clog2(REF_BASE) + 8;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;
  logic          req_q;
  logic          tick;

  assign lim  = (CW'(REF_BASE) << div) - CW'(1);
  assign tick = (cnt_q >= lim);
  assign req  = req_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      cnt_q <= tick ? '0 : cnt_q + CW'(1);
      if (tick)     req_q <= 1'b1;
      else if (ack) req_q <= 1'b0;
    end
  end

  // R9
  ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_q && !ack |=> req_q);
endmodule

// File: rtl/xmem_seq.sv
module xmem_seq
  import xmem_pkg::*;
#(
  parameter int ROW_W   = 13,
  parameter int SA_W    = 22,
  parameter int REF_CYC = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 go,
  input  logic                 c_we,
  input  logic                 c_sram,
  input  logic [1:0]           c_size,
  input  logic [1:0]           c_wait,
  input  logic [2*ROW_W-1:0]   c_addr,
  input  logic [WORD_W-1:0]    c_wdata,
  input  logic                 ref_req,
  output logic                 ref_ack,
  output logic                 busy,
  output logic                 done,
  output logic [WORD_W-1:0]    rd_word,
  output logic                 mem_ras,
  output logic                 mem_cas,
  output logic                 mem_cs,
  output logic                 mem_we,
  output logic                 mem_refresh,
  output logic [SA_W-1:0]      mem_addr,
  output logic [2:0]           mem_beat,
  output logic [7:0]           mem_dout,
  input  logic [7:0]           mem_din
);
  localparam int EA_W = 2 * ROW_W;
  localparam int RC_W = $clog2(REF_CYC) + 1;

  sq_state_e         st_q;
  logic              pend_q, done_q, we_q, sram_q;
  logic [1:0]        size_q, wait_q, wcnt_q;
  logic [EA_W-1:0]   addr_q;
  logic [WORD_W-1:0] wd_q, rd_q, wshift;
  logic [2:0]        beat_q, nbeats;
  logic [RC_W-1:0]   rcnt_q;
  logic [5:0]        shamt;
  logic              beat_end, last_beat;

  assign nbeats    = beats_of(sram_q, size_q);
  assign beat_end  = !sram_q || (wcnt_q == wait_q);
  assign last_beat = (beat_q == nbeats - 3'd1);
  assign shamt     = sram_q ? {beat_q, 3'b000} : {1'b0, beat_q, 2'b00};
  assign wshift    = wd_q >> shamt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      pend_q <= 1'b0;
      done_q <= 1'b0;
      we_q   <= 1'b0;
      sram_q <= 1'b0;
      size_q <= '0;
      wait_q <= '0;
      wcnt_q <= '0;
      addr_q <= '0;
      wd_q   <= '0;
      rd_q   <= '0;
      beat_q <= '0;
      rcnt_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (go) begin
        pend_q <= 1'b1;
        we_q   <= c_we;
        sram_q <= c_sram;
        size_q <= c_size;
        wait_q <= c_wait;
        addr_q <= c_addr;
        wd_q   <= c_wdata;
        if (!c_we) rd_q <= '0;
      end
      unique case (st_q)
        SQ_IDLE: begin
          if (ref_req) begin
            st_q   <= SQ_REF;
            rcnt_q <= '0;
          end else if (pend_q) begin
            st_q   <= sram_q ? SQ_BEAT : SQ_ROW;
            beat_q <= '0;
            wcnt_q <= '0;
          end
        end
        SQ_REF: begin
          if (rcnt_q == RC_W'(REF_CYC - 1)) st_q <= SQ_IDLE;
          else rcnt_q <= rcnt_q + RC_W'(1);
        end
        SQ_ROW: st_q <= SQ_BEAT;
        SQ_BEAT: begin
          if (beat_end) begin
            wcnt_q <= '0;
            if (!we_q)
              rd_q <= rd_q | ((sram_q ? WORD_W'(mem_din) : WORD_W'(mem_din[3:0])) << shamt);
            if (last_beat) begin
              st_q   <= SQ_IDLE;
              pend_q <= 1'b0;
              done_q <= 1'b1;
            end else begin
              beat_q <= beat_q + 3'd1;
            end
          end else begin
            wcnt_q <= wcnt_q + 2'd1;
          end
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  assign ref_ack     = (st_q == SQ_IDLE) && ref_req;
  assign busy        = pend_q;
  assign done        = done_q;
  assign rd_word     = rd_q;
  assign mem_ras     = (st_q == SQ_ROW);
  assign mem_cas     = (st_q == SQ_BEAT) && !sram_q;
  assign mem_cs      = (st_q == SQ_BEAT) && sram_q;
  assign mem_we      = ((st_q == SQ_ROW) || (st_q == SQ_BEAT)) && we_q;
  assign mem_refresh = (st_q == SQ_REF);
  assign mem_beat    = (st_q == SQ_BEAT) ? beat_q : 3'd0;

  always_comb begin
    mem_addr = '0;
    mem_dout = 8'h00;
    if (st_q == SQ_ROW) mem_addr = SA_W'(addr_q[EA_W-1:ROW_W]);
    if (st_q == SQ_BEAT) begin
      mem_addr = sram_q ? addr_q[SA_W-1:0] : SA_W'(addr_q[ROW_W-1:0]);
      if (we_q) mem_dout = sram_q ? wshift[7:0] : {4'b0000, wshift[3:0]};
    end
  end

  // R4
  ras_then_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ras |=> mem_cas);
  // R2
  beat_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_BEAT) |-> (beat_q < nbeats));
  // R10
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  // R9
  ref_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_refresh) |-> $past(st_q) == SQ_IDLE);
endmodule

// File: rtl/xmem_regs.sv
module xmem_regs
  import xmem_pkg::*;
#(
  parameter int EA_W = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              busy,
  input  logic              done,
  input  logic [WORD_W-1:0] rd_word,
  output logic              go,
  output logic              c_we,
  output logic [EA_W-1:0]   c_addr,
  output logic [WORD_W-1:0] c_wdata,
  output logic              c_sram,
  output logic [1:0]        c_size,
  output logic [1:0]        c_wait,
  output logic [2:0]        ref_div,
  output logic              irq
);
  logic [CFG_W-1:0] cfg_q;
  logic [EA_W-1:0]  base_q, ofsa_q, ofsb_q, sel_ofs;
  logic             done_f, err_q, wr_ok, rd_trig, rd_mode;

  assign rd_mode = cfg_q[CB_RDM];
  assign sel_ofs = cfg_q[CB_OSEL] ? ofsb_q : ofsa_q;
  assign wr_ok   = reg_wr && !busy;
  assign rd_trig = reg_rd && (reg_addr == RA_RDAT) && rd_mode;
  assign c_wdata = reg_wdata[WORD_W-1:0];
  assign c_sram  = cfg_q[CB_SRAM];
  assign c_size  = cfg_q[2:1];
  assign c_wait  = cfg_q[4:3];
  assign ref_div = cfg_q[7:5];
  assign irq     = done_f && cfg_q[CB_IRQ];

  always_comb begin
    go     = 1'b0;
    c_we   = 1'b0;
    c_addr = base_q + sel_ofs;
    if (wr_ok) begin
      if (reg_addr == RA_WDAT) begin
        go   = 1'b1;
        c_we = 1'b1;
      end else if ((reg_addr == RA_OFSA || reg_addr == RA_OFSB) && !rd_mode) begin
        go     = 1'b1;
        c_addr = base_q + reg_wdata[EA_W-1:0];
      end
    end else if (rd_trig && !busy && !reg_wr) begin
      go = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      base_q <= '0;
      ofsa_q <= '0;
      ofsb_q <= '0;
      done_f <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (go) done_f <= 1'b0;
      else if (done) done_f <= 1'b1;
      if (busy && (reg_wr || rd_trig)) err_q <= 1'b1;
      if (wr_ok) begin
        unique case (reg_addr)
          RA_CFG: begin
            cfg_q <= reg_wdata[CFG_W-1:0];
            if (reg_wdata[WB_ECLR]) err_q <= 1'b0;
          end
          RA_BASE: base_q <= reg_wdata[EA_W-1:0];
          RA_OFSA: ofsa_q <= reg_wdata[EA_W-1:0];
          RA_OFSB: ofsb_q <= reg_wdata[EA_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      RA_CFG: begin
        reg_rdata[CFG_W-1:0] = cfg_q;
        reg_rdata[SB_BUSY]   = busy;
        reg_rdata[SB_DONE]   = done_f;
        reg_rdata[SB_ERR]    = err_q;
      end
      RA_RDAT: reg_rdata = REG_W'(rd_word);
      RA_BASE: reg_rdata = REG_W'(base_q);
      RA_OFSA: reg_rdata = REG_W'(ofsa_q);
      RA_OFSB: reg_rdata = REG_W'(ofsb_q);
      default: reg_rdata = '0;
    endcase
  end

  // R11
  busy_write_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && busy |=> err_q);
  // R11
  busy_base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && busy && (reg_addr == RA_BASE) |=> $stable(base_q));
  // R10
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> !irq);
endmodule

// File: rtl/xmem_ctrl.sv
module xmem_ctrl
  import xmem_pkg::*;
#(
  parameter int ROW_W    = 13,
  parameter int SA_W     = 22,
  parameter int REF_BASE = 256,
  parameter int REF_CYC  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq,
  output logic              mem_ras,
  output logic              mem_cas,
  output logic              mem_cs,
  output logic              mem_we,
  output logic              mem_refresh,
  output logic [SA_W-1:0]   mem_addr,
  output logic [2:0]        mem_beat,
  output logic [7:0]        mem_dout,
  input  logic [7:0]        mem_din
);
  localparam int EA_W = 2 * ROW_W;

  logic              go, c_we, c_sram, busy, done, ref_req, ref_ack;
  logic [1:0]        c_size, c_wait;
  logic [2:0]        ref_div;
  logic [EA_W-1:0]   c_addr;
  logic [WORD_W-1:0] c_wdata, rd_word;

  xmem_regs #(.EA_W(EA_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .busy(busy), .done(done), .rd_word(rd_word), .go(go), .c_we(c_we),
    .c_addr(c_addr), .c_wdata(c_wdata), .c_sram(c_sram), .c_size(c_size),
    .c_wait(c_wait), .ref_div(ref_div), .irq(irq)
  );

  xmem_refresh #(.REF_BASE(REF_BASE)) ref_i (
    .clk(clk), .rst_n(rst_n), .div(ref_div), .ack(ref_ack), .req(ref_req)
  );

  xmem_seq #(.ROW_W(ROW_W), .SA_W(SA_W), .REF_CYC(REF_CYC)) seq_i (
    .clk(clk), .rst_n(rst_n), .go(go), .c_we(c_we), .c_sram(c_sram),
    .c_size(c_size), .c_wait(c_wait), .c_addr(c_addr), .c_wdata(c_wdata),
    .ref_req(ref_req), .ref_ack(ref_ack), .busy(busy), .done(done),
    .rd_word(rd_word), .mem_ras(mem_ras), .mem_cas(mem_cas), .mem_cs(mem_cs),
    .mem_we(mem_we), .mem_refresh(mem_refresh), .mem_addr(mem_addr),
    .mem_beat(mem_beat), .mem_dout(mem_dout), .mem_din(mem_din)
  );
endmodule

// File: tb/xmem_ctrl_tb_top.sv
`timescale 1ns/1ps
module xmem_ctrl_tb_top;
  localparam int ROW_W = 13;
  localparam int SA_W  = 22;
  localparam int EA_W  = 2 * ROW_W;
  localparam int KW    = 1 + EA_W + 3;
  localparam int RBASE = 16;
  localparam int RCYC  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic irq, mem_ras, mem_cas, mem_cs, mem_we, mem_refresh;
  logic [SA_W-1:0] mem_addr;
  logic [2:0] mem_beat;
  logic [7:0] mem_dout;
  logic [7:0] mem_din = 8'h00;

  always #5 clk = ~clk;

  xmem_ctrl #(.ROW_W(ROW_W), .SA_W(SA_W), .REF_BASE(RBASE), .REF_CYC(RCYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .mem_ras(mem_ras),
    .mem_cas(mem_cas), .mem_cs(mem_cs), .mem_we(mem_we), .mem_refresh(mem_refresh),
    .mem_addr(mem_addr), .mem_beat(mem_beat), .mem_dout(mem_dout), .mem_din(mem_din)
  );

  int nchk = 0, nfail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // external memory model and bus monitor
  logic [7:0] mdl [logic [KW-1:0]];
  int cyc = 0, ncas = 0, ncs = 0, nras = 0, novl = 0, nrise = 0;
  int last_rise = 0, gap = 0, pw_cur = 0, last_pw = 0;
  logic [ROW_W-1:0] row_seen = '0, col_seen = '0;
  logic [SA_W-1:0] sa_seen = '0;
  logic ref_prev = 1'b0;

  function automatic logic [KW-1:0] key_of(input bit sram, input logic [EA_W-1:0] a, input logic [2:0] b);
    return {sram, a, b};
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    logic [KW-1:0] k;
    logic [7:0] v;
    v = 8'h00;
    if (mem_ras) begin nras++; row_seen = mem_addr[ROW_W-1:0]; end
    if (mem_cas) begin
      ncas++;
      col_seen = mem_addr[ROW_W-1:0];
      k = key_of(1'b0, {row_seen, mem_addr[ROW_W-1:0]}, mem_beat);
      if (mem_we) mdl[k] = {4'h0, mem_dout[3:0]};
      else if (mdl.exists(k)) v = mdl[k];
    end
    if (mem_cs) begin
      ncs++;
      sa_seen = mem_addr;
      k = key_of(1'b1, EA_W'(mem_addr), mem_beat);
      if (mem_we) mdl[k] = mem_dout;
      else if (mdl.exists(k)) v = mdl[k];
    end
    mem_din <= v;
    if (mem_refresh) begin
      if (!ref_prev) begin
        gap = cyc - last_rise;
        last_rise = cyc;
        nrise++;
        pw_cur = 0;
      end
      pw_cur++;
    end else if (ref_prev) last_pw = pw_cur;
    ref_prev = mem_refresh;
    if (mem_refresh && (mem_cas || mem_cs || mem_ras)) novl++;
  end

  // scoreboard
  logic [23:0] exp_q[$];
  string tag_q[$];
  logic [23:0] rd_seen;
  event rd_ev;

  initial forever begin
    @(rd_ev);
    if (exp_q.size() == 0) chk(1'b0, "R7 unexpected read", 32'(rd_seen), 0);
    else begin
      logic [23:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(rd_seen == e, t, 32'(rd_seen), 32'(e));
    end
  end

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic expect_rd(input logic [23:0] v, input string t);
    exp_q.push_back(v);
    tag_q.push_back(t);
  endtask

  task automatic pop_rd();
    logic [31:0] d;
    reg_read(3'd2, d);
    rd_seen = d[23:0];
    ->rd_ev;
    #1;
  endtask

  task automatic wait_idle(input string req);
    logic [31:0] s;
    for (int i = 0; i < 400; i++) begin
      reg_read(3'd0, s);
      if (!s[16]) return;
    end
    chk(1'b0, req, s, 0);
  endtask

  task automatic clr_mon();
    ncas = 0; ncs = 0; nras = 0;
  endtask

  function automatic logic [31:0] cfgw(input bit sram, input int size, input int wt, input int dv,
                                       input bit mode1, input bit sel, input bit irqen);
    return 32'(sram) | (32'(size) << 1) | (32'(wt) << 3) | (32'(dv) << 5) |
           (32'(mode1) << 8) | (32'(sel) << 9) | (32'(irqen) << 10);
  endfunction

  task automatic report();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL R10 watchdog actual=hung expected=done");
      report();
      $finish;
    end
  end

  initial begin
    logic [31:0] s, d;
    logic [EA_W-1:0] base, ofa, ofb, ea0, ea1, eb;
    base = 26'h2D4B1C9; ofa = 26'h0000137; ofb = 26'h3FFFFF0;
    ea0 = base + ofa; ea1 = base + ofb;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    reg_read(3'd0, s);
    chk(s == 0, "R1 status", s, 0);
    chk({irq, mem_ras, mem_cas, mem_cs, mem_we} == 5'b0, "R1 strobes",
        32'({irq, mem_ras, mem_cas, mem_cs, mem_we}), 0);

    reg_write(3'd0, cfgw(0, 1, 0, 7, 1, 0, 1));
    reg_write(3'd3, 32'(base));
    reg_write(3'd4, 32'(ofa));
    reg_write(3'd5, 32'(ofb));
    wait_idle("R8 no launch");
    chk(nras == 0, "R8 offset write in mode 1 starts nothing", nras, 0);

    // DRAM 16-bit write (R6)
    clr_mon();
    reg_write(3'd1, 32'h00A5C37E);
    reg_read(3'd0, s);
    chk(s[16] == 1'b1, "R10 busy after start", s[16], 1);
    chk(irq == 1'b0, "R10 irq low while busy", irq, 0);
    wait_idle("R10");
    chk(nras == 1 && row_seen == ea0[25:13], "R4 row", 32'(row_seen), 32'(ea0[25:13]));
    chk(col_seen == ea0[12:0], "R4 column", 32'(col_seen), 32'(ea0[12:0]));
    chk(ncas == 4, "R2 16-bit beat count", ncas, 4);
    chk(mdl[key_of(0, ea0, 3'd0)] == 8'h0E, "R2 first nibble", 32'(mdl[key_of(0, ea0, 3'd0)]), 32'hE);
    chk(mdl[key_of(0, ea0, 3'd3)] == 8'h0C, "R2 fourth nibble", 32'(mdl[key_of(0, ea0, 3'd3)]), 32'hC);
    reg_read(3'd0, s);
    chk(s[17] == 1'b1 && irq == 1'b1, "R10 done and irq", {s[17], irq}, 3);

    // read back through an offset write (R7)
    reg_write(3'd0, cfgw(0, 1, 0, 7, 0, 0, 1));
    reg_write(3'd4, 32'(ofa));
    wait_idle("R7");
    expect_rd(24'h00C37E, "R7 R2 read on offset write");
    pop_rd();

    // DRAM 24-bit with offset B and wrapping address, read mode 1 (R8)
    reg_write(3'd0, cfgw(0, 2, 0, 7, 1, 1, 0));
    clr_mon();
    reg_write(3'd1, 32'h005B9D2F);
    wait_idle("R6");
    chk(ncas == 6, "R2 24-bit beat count", ncas, 6);
    chk(row_seen == ea1[25:13], "R6 wrapped address", 32'(row_seen), 32'(ea1[25:13]));
    reg_read(3'd2, d);
    chk(d[23:0] == 24'h00C37E, "R8 returns previous word", d, 32'h00C37E);
    wait_idle("R8");
    expect_rd(24'h5B9D2F, "R8 R2 24-bit read");
    pop_rd();
    wait_idle("R8");

    // busy refusal (R11)
    reg_write(3'd1, 32'h00123456);
    reg_write(3'd3, 32'h0000_0AAA);
    wait_idle("R11");
    reg_read(3'd3, d);
    chk(d == 32'(base), "R11 base unchanged", d, 32'(base));
    reg_read(3'd0, s);
    chk(s[18] == 1'b1, "R11 error set", s[18], 1);
    reg_write(3'd0, cfgw(0, 2, 0, 7, 1, 1, 0) | 32'h8000_0000);
    reg_read(3'd0, s);
    chk(s[18] == 1'b0, "R11 error cleared", s[18], 0);

    // SRAM sizes and wait settings (R3, R5)
    for (int sz = 0; sz < 3; sz++) begin
      for (int wt = 0; wt < 4; wt++) begin
        logic [23:0] dw, mask;
        dw = 24'h3C5A96 ^ (24'(sz * 16 + wt) * 24'h010101);
        mask = (sz == 0) ? 24'h0000FF : (sz == 1) ? 24'h00FFFF : 24'hFFFFFF;
        reg_write(3'd0, cfgw(1, sz, wt, 7, 0, 0, 0));
        clr_mon();
        reg_write(3'd1, 32'(dw));
        wait_idle("R5");
        chk(ncs == (sz + 1) * (wt + 1), "R5 R3 select cycles", ncs, (sz + 1) * (wt + 1));
        chk(sa_seen == ea0[SA_W-1:0], "R5 address", 32'(sa_seen), 32'(ea0[SA_W-1:0]));
        chk(mdl[key_of(1, EA_W'(ea0[SA_W-1:0]), 3'd0)] == dw[7:0], "R3 first byte",
            32'(mdl[key_of(1, EA_W'(ea0[SA_W-1:0]), 3'd0)]), 32'(dw[7:0]));
        reg_write(3'd4, 32'(ofa));
        wait_idle("R3");
        expect_rd(dw & mask, "R3 read word");
        pop_rd();
      end
    end

    // refresh pacing (R9)
    reg_write(3'd0, cfgw(1, 2, 3, 0, 0, 0, 0));
    begin
      int n0;
      n0 = nrise;
      for (int i = 0; i < 400 && nrise < n0 + 3; i++) @(negedge clk);
    end
    chk(gap == RBASE, "R9 interval divider 0", gap, RBASE);
    chk(last_pw == RCYC, "R9 pulse length", last_pw, RCYC);

    // accesses overlapping refresh requests (R9)
    novl = 0;
    for (int i = 0; i < 3; i++) begin
      logic [23:0] dw;
      dw = 24'hC0FFEE + 24'(i * 24'h111111);
      eb = base + 26'(i * 8);
      reg_write(3'd1, 32'(dw));
      wait_idle("R9");
      reg_write(3'd0, cfgw(1, 2, 3, 0, 1, 0, 0));
      reg_write(3'd4, 32'(i * 8 + 8));
      reg_write(3'd0, cfgw(1, 2, 3, 0, 0, 0, 0));
      reg_write(3'd4, 32'(ofa));
      wait_idle("R9");
      expect_rd(dw, "R9 word intact across refresh");
      pop_rd();
      if (eb == 0) chk(1'b0, "R9 address", 0, 1);
    end
    chk(novl == 0, "R9 no refresh inside a word", novl, 0);

    reg_write(3'd0, cfgw(1, 2, 3, 2, 0, 0, 0));
    begin
      int n0;
      n0 = nrise;
      for (int i = 0; i < 600 && nrise < n0 + 3; i++) @(negedge clk);
    end
    chk(gap == RBASE * 4, "R9 interval divider 2", gap, RBASE * 4);

    chk(exp_q.size() == 0, "R7 scoreboard drained", exp_q.size(), 0);
    finished = 1;
    report();
    $finish;
  end
endmodule